// File: doc/BRIEF.md
# Configuration Cycle Address Router

This block gives a host bridge the classic two-port I/O mechanism for reaching configuration space. Software first writes a 32-bit address word to the address port. The word holds an enable flag, a bus number, a device number, a function number and a dword register index. Software then reads or writes the data-window port.

The router decodes the stored address and turns the data-window access into a configuration transaction aimed at exactly one target. On bus 0, the lower half of the device space belongs to the legacy PCI segment. The upper half holds a fixed map of system-bus agents: a memory/IO controller, two I/O bridges with two segments each, and up to three third-party agents. The remaining upper slots, non-zero buses and non-zero functions on the single-function bridge agents have no target. Such an access completes locally: a read returns all ones and a write is dropped.

The host side is a request/acknowledge pair. The host holds `io_req` and its fields stable until `io_ack` pulses for one cycle, and it drops `io_req` in the cycle after the acknowledge. A routed access stays pending until the selected target pulses its completion. The target's read data is forwarded in that same cycle.

Top module: `cfg_access_router`

## Requirements
- R1: After reset, the stored address word is zero, no target select is active and `io_ack` is low.
- R2: A write to the address port (0xCF8) with all four byte enables set stores the word. A read of that port returns it with bits 30:24 and 1:0 forced to zero. Both acknowledge in the cycle after the request is accepted.
- R3: A write to the address port with any byte enable clear is acknowledged and leaves the stored word unchanged.
- R4: When stored bit 31 (enable) is 0, a data-port (0xCFC) access selects no target: a read returns 0xFFFFFFFF, a write is discarded, and the acknowledge follows one cycle after acceptance.
- R5: With enable set, bus (bits 23:16) equal to 0 and device (bits 15:11) from 0 to 15, the access goes to the legacy segment, `tgt_sel` bit 0, whatever the function number.
- R6: On bus 0 the upper devices map to these `tgt_sel` bits: 0x10 to bit 1 (memory/IO controller), 0x12..0x15 to bits 2..5 (bridge 0 segment a, bridge 0 segment b, bridge 1 segment a, bridge 1 segment b), and 0x1C..0x1E to bits 6..8 (third-party agents).
- R7: Device 0x11, devices 0x16..0x1B, device 0x1F and any bus other than 0 select no target: a read returns 0xFFFFFFFF and a write is discarded.
- R8: A non-zero function (bits 10:8) to device 0x10 or 0x12..0x15 selects no target. A non-zero function to a third-party agent is routed normally.
- R9: A routed access holds its select until that target's `tgt_done` bit is high. `io_ack` and the target's read data appear in that same cycle. Completion pulses from unselected targets are ignored.
- R10: A routed access presents the host's write flag, byte enables and write data unchanged, together with the device, function and register (bits 7:2) fields of the stored word.
- R11: A request to any I/O port other than the address and data ports is never acknowledged.
- R12: At most one `tgt_sel` bit is high at any time, and `io_ack` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host I/O request, held until acknowledged |
| io_addr | input | IO_AW | Host I/O port address |
| io_we | input | 1 | Host write flag |
| io_be | input | 4 | Host byte enables |
| io_wdata | input | 32 | Host write data |
| io_ack | output | 1 | One-cycle completion to host |
| io_rdata | output | 32 | Read data, valid with io_ack |
| tgt_sel | output | 6+N_THIRD | One-hot target select, held while pending |
| tgt_we | output | 1 | Configuration write flag |
| tgt_be | output | 4 | Configuration byte enables |
| tgt_wdata | output | 32 | Configuration write data |
| tgt_dev | output | 5 | Device number |
| tgt_func | output | 3 | Function number |
| tgt_reg | output | 6 | Dword register index |
| tgt_done | input | 6+N_THIRD | Per-target completion pulse |
| tgt_rdata | input | 32*(6+N_THIRD) | Per-target read data, target i in slice i |

## Verification
Two events can fall in the same cycle: the selected target's completion, and completion pulses from every other target. The bench model can be told to raise all unselected `tgt_done` bits in every cycle while a transaction is pending. Each target also drives its own distinct read pattern at all times. A correct router must acknowledge exactly when its own target finishes, after that target's latency and not earlier. It must also return that target's pattern and not a mix of the other slots. Both are checked against latencies and patterns the bench derives from the target index.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  localparam int IDX_W    = 4;
  localparam int DW       = 32;
  localparam int BASE_TGT = 6;

  localparam logic [IDX_W-1:0] TGT_LEGACY = 4'd0;
  localparam logic [IDX_W-1:0] TGT_MEMCTL = 4'd1;
  localparam logic [IDX_W-1:0] TGT_BRIDGE = 4'd2;
  localparam logic [IDX_W-1:0] TGT_THIRD  = 4'd6;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] rg;
  } cfg_addr_t;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } route_t;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WAIT = 2'd1,
    XS_RESP = 2'd2
  } xstate_e;

  // Split a host word into the stored fields.
  function automatic cfg_addr_t unpack_addr(input logic [DW-1:0] w);
    cfg_addr_t a;
    a.en  = w[31];
    a.bus = w[23:16];
    a.dev = w[15:11];
    a.fn  = w[10:8];
    a.rg  = w[7:2];
    return a;
  endfunction

  // Rebuild the readable word; reserved bits come back as zero.
  function automatic logic [DW-1:0] pack_addr(input cfg_addr_t a);
    return {a.en, 7'b0, a.bus, a.dev, a.fn, a.rg, 2'b00};
  endfunction

  // Map bus/device/function to a target index, or report no target.
  function automatic route_t route_lookup(input cfg_addr_t a, input int n_third);
    route_t     r;
    logic [3:0] lo;
    r  = '0;
    lo = a.dev[3:0];
    if (a.bus == 8'd0) begin
      if (!a.dev[4]) begin
        r.hit = 1'b1;
        r.idx = TGT_LEGACY;
      end else if (lo == 4'h0) begin
        r.hit = (a.fn == 3'd0);
        r.idx = TGT_MEMCTL;
      end else if (lo >= 4'h2 && lo <= 4'h5) begin
        r.hit = (a.fn == 3'd0);
        r.idx = TGT_BRIDGE + (lo - 4'h2);
      end else if (lo >= 4'hC && int'(lo) < 12 + n_third && lo != 4'hF) begin
        r.hit = 1'b1;
        r.idx = TGT_THIRD + (lo - 4'hC);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgr_addr_reg.sv
module cfgr_addr_reg
  import cfgr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output cfg_addr_t     cfg,
  output logic [DW-1:0] rd_word
);

  cfg_addr_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= unpack_addr(wr_data);
  end

  assign cfg     = cfg_q;
  assign rd_word = pack_addr(cfg_q);

endmodule

// File: rtl/cfgr_decode.sv
module cfgr_decode
  import cfgr_pkg::*;
#(
  parameter int N_THIRD = 3
) (
  input  cfg_addr_t cfg,
  output route_t    route,
  output logic      route_ok
);

  always_comb begin
    route    = route_lookup(cfg, N_THIRD);
    route_ok = cfg.en & route.hit;
  end

endmodule

// File: rtl/cfgr_xact.sv
module cfgr_xact
  import cfgr_pkg::*;
#(
  parameter int N_THIRD = 3,
  localparam int NT = BASE_TGT + N_THIRD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             on_addr_port,
  input  logic             on_data_port,
  input  logic             io_we,
  input  logic [3:0]       io_be,
  input  logic [DW-1:0]    io_wdata,
  input  cfg_addr_t        cfg,
  input  logic [DW-1:0]    addr_word,
  input  route_t           route,
  input  logic             route_ok,
  input  logic [NT-1:0]    tgt_done,
  input  logic [NT*DW-1:0] tgt_rdata,
  output logic             io_ack,
  output logic [DW-1:0]    io_rdata,
  output logic [NT-1:0]    tgt_sel,
  output logic             tgt_we,
  output logic [3:0]       tgt_be,
  output logic [DW-1:0]    tgt_wdata,
  output logic [4:0]       tgt_dev,
  output logic [2:0]       tgt_func,
  output logic [5:0]       tgt_reg,
  output logic             addr_wr,
  output logic             ev_accept_local,
  output logic             ev_accept_route,
  output logic             busy
);

  xstate_e       state_q;
  logic [DW-1:0] resp_q;
  logic          accept;
  logic          own_done;
  logic [DW-1:0] ret_data;
  logic [DW-1:0] ret_lane [NT];

  assign accept          = (state_q == XS_IDLE) & io_req & (on_addr_port | on_data_port);
  assign ev_accept_route = accept & on_data_port & route_ok;
  assign ev_accept_local = accept & ~ev_accept_route;
  assign addr_wr         = accept & on_addr_port & io_we & (io_be == 4'hF);
  assign own_done        = |(tgt_sel & tgt_done);
  assign busy            = (state_q != XS_IDLE);

  // Read return: each lane gated by its own select bit, then OR-merged.
  genvar gi;
  generate
    for (gi = 0; gi < NT; gi++) begin : g_lane
      assign ret_lane[gi] = tgt_rdata[gi*DW +: DW] & {DW{tgt_sel[gi]}};
    end
  endgenerate

  always_comb begin
    ret_data = '0;
    for (int i = 0; i < NT; i++) ret_data = ret_data | ret_lane[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= XS_IDLE;
      resp_q    <= '0;
      tgt_sel   <= '0;
      tgt_we    <= 1'b0;
      tgt_be    <= '0;
      tgt_wdata <= '0;
      tgt_dev   <= '0;
      tgt_func  <= '0;
      tgt_reg   <= '0;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (ev_accept_route) begin
            state_q   <= XS_WAIT;
            tgt_sel   <= NT'(1) << route.idx;
            tgt_we    <= io_we;
            tgt_be    <= io_be;
            tgt_wdata <= io_wdata;
            tgt_dev   <= cfg.dev;
            tgt_func  <= cfg.fn;
            tgt_reg   <= cfg.rg;
          end else if (ev_accept_local) begin
            state_q <= XS_RESP;
            resp_q  <= (on_addr_port && !io_we) ? addr_word : '1;
          end
        end
        XS_WAIT: begin
          if (own_done) begin
            state_q <= XS_IDLE;
            tgt_sel <= '0;
          end
        end
        XS_RESP: state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign io_ack   = (state_q == XS_RESP) | ((state_q == XS_WAIT) & own_done);
  assign io_rdata = (state_q == XS_WAIT) ? ret_data : resp_q;

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfgr_pkg::*;
#(
  parameter int                IO_AW     = 16,
  parameter int                N_THIRD   = 3,
  parameter logic [IO_AW-1:0]  ADDR_PORT = 'h0CF8,
  parameter logic [IO_AW-1:0]  DATA_PORT = 'h0CFC,
  localparam int               NT        = BASE_TGT + N_THIRD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_we,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic             io_ack,
  output logic [31:0]      io_rdata,
  output logic [NT-1:0]    tgt_sel,
  output logic             tgt_we,
  output logic [3:0]       tgt_be,
  output logic [31:0]      tgt_wdata,
  output logic [4:0]       tgt_dev,
  output logic [2:0]       tgt_func,
  output logic [5:0]       tgt_reg,
  input  logic [NT-1:0]    tgt_done,
  input  logic [NT*32-1:0] tgt_rdata
);

  logic      on_addr_port;
  logic      on_data_port;
  logic      addr_wr;
  cfg_addr_t cfg;
  logic [31:0] addr_word;
  route_t    route;
  logic      route_ok;
  logic      ev_accept_local;
  logic      ev_accept_route;
  logic      busy;

  assign on_addr_port = (io_addr == ADDR_PORT);
  assign on_data_port = (io_addr == DATA_PORT);

  cfgr_addr_reg u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (addr_wr),
    .wr_data (io_wdata),
    .cfg     (cfg),
    .rd_word (addr_word)
  );

  cfgr_decode #(.N_THIRD(N_THIRD)) u_dec (
    .cfg      (cfg),
    .route    (route),
    .route_ok (route_ok)
  );

  cfgr_xact #(.N_THIRD(N_THIRD)) u_xact (
    .clk             (clk),
    .rst_n           (rst_n),
    .io_req          (io_req),
    .on_addr_port    (on_addr_port),
    .on_data_port    (on_data_port),
    .io_we           (io_we),
    .io_be           (io_be),
    .io_wdata        (io_wdata),
    .cfg             (cfg),
    .addr_word       (addr_word),
    .route           (route),
    .route_ok        (route_ok),
    .tgt_done        (tgt_done),
    .tgt_rdata       (tgt_rdata),
    .io_ack          (io_ack),
    .io_rdata        (io_rdata),
    .tgt_sel         (tgt_sel),
    .tgt_we          (tgt_we),
    .tgt_be          (tgt_be),
    .tgt_wdata       (tgt_wdata),
    .tgt_dev         (tgt_dev),
    .tgt_func        (tgt_func),
    .tgt_reg         (tgt_reg),
    .addr_wr         (addr_wr),
    .ev_accept_local (ev_accept_local),
    .ev_accept_route (ev_accept_route),
    .busy            (busy)
  );

endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
  parameter int               IO_AW     = 16,
  parameter int               N_THIRD   = 3,
  parameter logic [IO_AW-1:0] ADDR_PORT = 'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 'h0CFC
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 io_req,
  input logic [IO_AW-1:0]     io_addr,
  input logic                 io_we,
  input logic                 io_ack,
  input logic [31:0]          io_rdata,
  input logic [5+N_THIRD:0]   tgt_sel,
  input logic [5+N_THIRD:0]   tgt_done,
  input logic [3:0]           tgt_be,
  input logic [31:0]          tgt_wdata,
  input logic                 ev_accept_local,
  input logic                 ev_accept_route,
  input logic                 busy
);

  logic pending;
  logic other_port;
  assign pending    = |tgt_sel;
  assign other_port = (io_addr != ADDR_PORT) && (io_addr != DATA_PORT);

  assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    io_ack |=> !io_ack);

  assert_local_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_local |=> (io_ack && !pending));

  assert_route_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_route |=> pending);

  // Covers R4, R7 and R8: every unrouted data-port read returns all ones.
  assert_miss_allones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept_local && io_addr == DATA_PORT && !io_we) |=> (io_rdata == 32'hFFFF_FFFF));

  assert_addr_rd_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ack && !pending && io_req && !io_we && io_addr == ADDR_PORT)
      |-> (io_rdata[30:24] == 7'd0 && io_rdata[1:0] == 2'd0));

  assert_ack_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (io_ack == |(tgt_sel & tgt_done)));

  assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !(|(tgt_sel & tgt_done))) |=>
      ($stable(tgt_sel) && $stable(tgt_be) && $stable(tgt_wdata)));

  assert_other_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && other_port && !busy) |=> !io_ack);

endmodule

bind cfg_access_router cfgr_checker #(
  .IO_AW(IO_AW), .N_THIRD(N_THIRD), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .io_req          (io_req),
  .io_addr         (io_addr),
  .io_we           (io_we),
  .io_ack          (io_ack),
  .io_rdata        (io_rdata),
  .tgt_sel         (tgt_sel),
  .tgt_done        (tgt_done),
  .tgt_be          (tgt_be),
  .tgt_wdata       (tgt_wdata),
  .ev_accept_local (ev_accept_local),
  .ev_accept_route (ev_accept_route),
  .busy            (busy)
);

// File: tb/tb_cfg_access_router.sv
module tb_cfg_access_router;

  localparam int NT = 9;
  localparam logic [15:0] PA = 16'h0CF8;
  localparam logic [15:0] PD = 16'h0CFC;
  localparam logic [3:0]  NONE = 4'hF;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] rg;
    logic       we;
    logic [3:0] be;
    logic [3:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd0, 5'h03, 3'd2, 6'd5,  1'b0, 4'hF, 4'd0},
    '{1'b1, 8'd0, 5'h0F, 3'd0, 6'd1,  1'b1, 4'h3, 4'd0},
    '{1'b1, 8'd0, 5'h10, 3'd0, 6'd2,  1'b0, 4'hF, 4'd1},
    '{1'b1, 8'd0, 5'h12, 3'd0, 6'd9,  1'b0, 4'hF, 4'd2},
    '{1'b1, 8'd0, 5'h13, 3'd0, 6'd10, 1'b1, 4'h8, 4'd3},
    '{1'b1, 8'd0, 5'h14, 3'd0, 6'd11, 1'b0, 4'hF, 4'd4},
    '{1'b1, 8'd0, 5'h15, 3'd0, 6'd63, 1'b1, 4'h6, 4'd5},
    '{1'b1, 8'd0, 5'h1C, 3'd0, 6'd12, 1'b0, 4'hF, 4'd6},
    '{1'b1, 8'd0, 5'h1D, 3'd5, 6'd13, 1'b0, 4'hF, 4'd7},
    '{1'b1, 8'd0, 5'h1E, 3'd0, 6'd14, 1'b1, 4'hF, 4'd8},
    '{1'b1, 8'd0, 5'h11, 3'd0, 6'd1,  1'b0, 4'hF, NONE},
    '{1'b1, 8'd0, 5'h18, 3'd0, 6'd1,  1'b1, 4'hF, NONE},
    '{1'b1, 8'd0, 5'h1F, 3'd0, 6'd1,  1'b0, 4'hF, NONE},
    '{1'b1, 8'd1, 5'h03, 3'd0, 6'd1,  1'b0, 4'hF, NONE},
    '{1'b1, 8'd0, 5'h10, 3'd1, 6'd1,  1'b0, 4'hF, NONE},
    '{1'b1, 8'd0, 5'h14, 3'd3, 6'd1,  1'b1, 4'hF, NONE},
    '{1'b0, 8'd0, 5'h03, 3'd0, 6'd1,  1'b0, 4'hF, NONE},
    '{1'b0, 8'd0, 5'h10, 3'd0, 6'd1,  1'b1, 4'hF, NONE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              io_req = 1'b0;
  logic [15:0]       io_addr = '0;
  logic              io_we = 1'b0;
  logic [3:0]        io_be = '0;
  logic [31:0]       io_wdata = '0;
  logic              io_ack;
  logic [31:0]       io_rdata;
  logic [NT-1:0]     tgt_sel;
  logic              tgt_we;
  logic [3:0]        tgt_be;
  logic [31:0]       tgt_wdata;
  logic [4:0]        tgt_dev;
  logic [2:0]        tgt_func;
  logic [5:0]        tgt_reg;
  logic [NT-1:0]     tgt_done = '0;
  logic [NT*32-1:0]  tgt_rdata = '0;

  cfg_access_router dut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr(io_addr), .io_we(io_we),
    .io_be(io_be), .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
    .tgt_sel(tgt_sel), .tgt_we(tgt_we), .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
    .tgt_dev(tgt_dev), .tgt_func(tgt_func), .tgt_reg(tgt_reg),
    .tgt_done(tgt_done), .tgt_rdata(tgt_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [NT-1:0] seen_sel = '0;
  logic stray_en = 1'b0;
  int cnt = 0;

  logic [NT-1:0] s_sel;
  logic s_we;
  logic [3:0] s_be;
  logic [31:0] s_wdata;
  logic [4:0] s_dev;
  logic [2:0] s_fn;
  logic [5:0] s_rg;

  function automatic int lat_of(input int idx);
    return 1 + (idx % 3);
  endfunction

  function automatic logic [31:0] pat_of(input int idx, input logic [5:0] rg);
    return 32'hC0DE_0000 | (32'(idx) << 8) | 32'(rg);
  endfunction

  // Target model: per-target latency, distinct data on every lane.
  always @(posedge clk) begin
    #1;
    if (!rst_n || tgt_sel == '0) begin
      cnt = 0;
      tgt_done = '0;
    end else begin
      int cur;
      logic [NT-1:0] dv;
      cur = 0;
      seen_sel = seen_sel | tgt_sel;
      for (int i = 0; i < NT; i++) if (tgt_sel[i]) cur = i;
      cnt++;
      dv = (cnt == lat_of(cur)) ? tgt_sel : '0;
      if (stray_en) dv = dv | ~tgt_sel;
      tgt_done = dv;
    end
    for (int i = 0; i < NT; i++) tgt_rdata[i*32 +: 32] = pat_of(i, tgt_reg);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io(input logic [15:0] a, input logic we, input logic [3:0] be,
                    input logic [31:0] wd, output logic [31:0] rd,
                    output int waits, output bit acked);
    @(negedge clk);
    io_req = 1'b1; io_addr = a; io_we = we; io_be = be; io_wdata = wd;
    waits = 0; acked = 1'b0; rd = '0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      waits++;
      if (io_ack) begin
        acked = 1'b1; rd = io_rdata;
        s_sel = tgt_sel; s_we = tgt_we; s_be = tgt_be; s_wdata = tgt_wdata;
        s_dev = tgt_dev; s_fn = tgt_func; s_rg = tgt_reg;
        break;
      end
    end
    io_req = 1'b0;
    if (acked) begin
      @(negedge clk);
      chk(io_ack == 1'b0, "R12 ack single cycle", 32'(io_ack), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int waits;
    bit acked;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(io_ack == 1'b0, "R1 ack low", 32'(io_ack), 32'd0);
    chk(tgt_sel == '0, "R1 no select", 32'(tgt_sel), 32'd0);
    io(PA, 1'b0, 4'hF, '0, rd, waits, acked);
    chk(acked && rd == 32'd0, "R1 address word zero", rd, 32'd0);

    // Masking and latency of the address port.
    io(PA, 1'b1, 4'hF, 32'hFFFF_FFFF, rd, waits, acked);
    chk(acked && waits == 1, "R2 write ack latency", 32'(waits), 32'd1);
    io(PA, 1'b0, 4'hF, '0, rd, waits, acked);
    chk(rd == 32'h80FF_FFFC, "R2 reserved bits read zero", rd, 32'h80FF_FFFC);
    chk(waits == 1, "R2 read ack latency", 32'(waits), 32'd1);

    // Partial write to the address port is ignored.
    io(PA, 1'b1, 4'hF, 32'h8012_3456, rd, waits, acked);
    io(PA, 1'b1, 4'h7, 32'h0000_0000, rd, waits, acked);
    chk(acked, "R3 partial write acked", 32'(acked), 32'd1);
    io(PA, 1'b0, 4'hF, '0, rd, waits, acked);
    chk(rd == 32'h8012_3454, "R3 word unchanged", rd, 32'h8012_3454);

    // Other ports get no acknowledge.
    io(16'h0080, 1'b0, 4'hF, '0, rd, waits, acked);
    chk(!acked, "R11 other port silent", 32'(acked), 32'd0);
    io(16'h0CF9, 1'b1, 4'hF, 32'h1234_5678, rd, waits, acked);
    chk(!acked, "R11 near port silent", 32'(acked), 32'd0);

    // Table-driven sweep of the device map.
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] wd;
      string tag;
      v = VECS[i];
      wd = 32'h5A00_0000 + 32'(i) * 32'h0101_0101;
      io(PA, 1'b1, 4'hF, {v.en, 7'b0, v.bus, v.dev, v.fn, v.rg, 2'b00}, rd, waits, acked);
      seen_sel = '0;
      io(PD, v.we, v.be, wd, rd, waits, acked);
      chk(acked, "R9 data access completes", 32'(acked), 32'd1);
      if (v.exp == NONE) begin
        if (!v.en) tag = "R4";
        else if (v.fn != 3'd0) tag = "R8";
        else tag = "R7";
        chk(seen_sel == '0, {tag, " no target"}, 32'(seen_sel), 32'd0);
        chk(waits == 1, {tag, " local latency"}, 32'(waits), 32'd1);
        if (!v.we) chk(rd == 32'hFFFF_FFFF, {tag, " all ones"}, rd, 32'hFFFF_FFFF);
      end else begin
        tag = (v.exp == 4'd0) ? "R5" : ((v.fn != 3'd0) ? "R8" : "R6");
        chk(s_sel == NT'(1) << v.exp, {tag, " target select"}, 32'(s_sel), 32'(NT'(1) << v.exp));
        chk(waits == lat_of(int'(v.exp)), "R9 ack with target done", 32'(waits),
            32'(lat_of(int'(v.exp))));
        chk(s_dev == v.dev && s_fn == v.fn && s_rg == v.rg, "R10 fields",
            {16'd0, s_dev, s_fn, s_rg, 2'b0}, {16'd0, v.dev, v.fn, v.rg, 2'b0});
        chk(s_we == v.we, "R10 write flag", 32'(s_we), 32'(v.we));
        if (v.we) begin
          chk(s_be == v.be, "R10 byte enables", 32'(s_be), 32'(v.be));
          chk(s_wdata == wd, "R10 write data", s_wdata, wd);
        end else begin
          chk(rd == pat_of(int'(v.exp), v.rg), "R9 read data", rd, pat_of(int'(v.exp), v.rg));
        end
      end
    end

    // Stray completions from unselected targets alongside the real one.
    stray_en = 1'b1;
    io(PA, 1'b1, 4'hF, {1'b1, 7'b0, 8'd0, 5'h14, 3'd0, 6'd33, 2'b00}, rd, waits, acked);
    io(PD, 1'b0, 4'hF, '0, rd, waits, acked);
    chk(waits == lat_of(4), "R9 stray done ignored", 32'(waits), 32'(lat_of(4)));
    chk(rd == pat_of(4, 6'd33), "R9 only own lane returned", rd, pat_of(4, 6'd33));
    io(PA, 1'b1, 4'hF, {1'b1, 7'b0, 8'd0, 5'h1E, 3'd0, 6'd7, 2'b00}, rd, waits, acked);
    io(PD, 1'b0, 4'hF, '0, rd, waits, acked);
    chk(waits == lat_of(8), "R9 stray done, slow target", 32'(waits), 32'(lat_of(8)));
    chk(rd == pat_of(8, 6'd7), "R9 slow target data", rd, pat_of(8, 6'd7));
    stray_en = 1'b0;

    // Enable cleared after a routed setup: no target.
    io(PA, 1'b1, 4'hF, {1'b0, 7'b0, 8'd0, 5'h12, 3'd0, 6'd4, 2'b00}, rd, waits, acked);
    seen_sel = '0;
    io(PD, 1'b0, 4'hF, '0, rd, waits, acked);
    chk(rd == 32'hFFFF_FFFF && seen_sel == '0, "R4 disabled read", rd, 32'hFFFF_FFFF);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule